// File: doc/BRIEF.md
# Prescaled Capture/Match Timer

This block is a general-purpose 32-bit timer. A prescale counter divides the clock and sends a count enable to a timer counter. Four compare channels watch the timer count. On a hit, each channel can drive its output pin low or high, toggle it, or leave it alone. A hit can also raise an interrupt, restart the counters or stop them. Four capture channels each synchronise an input pin. On the edge chosen by software, a capture channel copies the timer count into its own register. A pause input freezes both counters while it is held.

Software uses a single-cycle register port. Writes are taken on the clock edge while `bus_wr` is high. Reads return data combinationally from `bus_addr`. The word map is as follows:

- 0: control. Bit 0 is the counter enable. Bit 1 is the synchronous counter clear.
- 1: prescale terminal value.
- 2: prescale count (read-only).
- 3: timer count (read-only).
- 4: compare-channel control.
- 5: output action select.
- 6: capture-channel control.
- 7: interrupt status.
- 8 to 11: compare values of channels 0 to 3.
- 12 to 15: capture registers of channels 0 to 3 (read-only).

Top module: `capmatch_timer`

## Requirements
- R1: After reset every register reads 0, `match_o` is 0 and `irq_o` is 0.
- R2: The prescale count rises from 0 to the programmed prescale value P, then wraps to 0. At each wrap the timer count advances by one. After K enabled clock cycles that start from cleared counters, the timer count reads K/(P+1) and the prescale count reads K mod (P+1).
- R3: While control bit 1 is set, both counters read 0, even when the enable bit is set.
- R4: While `pause_i` is high, neither counter changes. Counting resumes when `pause_i` falls.
- R5: A compare event on channel n happens in a prescale-wrap cycle in which the timer count equals compare value n. The event sets status bit n.
- R6: Output action register bits [2n+1:2n] set what a compare event does to `match_o[n]`: 00 leaves it unchanged, 01 clears it, 10 sets it, 11 inverts it.
- R7: If compare-control bit 4n+1 is set, a compare event on channel n returns both counters to 0. The events then repeat every (M+1)(P+1) clock cycles.
- R8: If compare-control bit 4n+2 is set, a compare event on channel n clears the enable bit, and the timer count stays at the compare value.
- R9: Each capture input passes through two synchronising flops. Capture-control bit 3n enables rising-edge capture and bit 3n+1 enables falling-edge capture. An enabled edge loads the current timer count into capture register n and sets status bit 4+n. An edge that is not enabled leaves the register unchanged.
- R10: Status bits stay set until software writes 1 to them. `irq_o` is high when any status bit is set whose enable is set: compare-control bit 4n for bit n, and capture-control bit 3n+2 for bit 4+n.
- R11: Writes to the read-only words (prescale count, timer count, capture registers) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pause_i | input | 1 | Freezes both counters while high |
| cap_i | input | 4 | Asynchronous capture inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| match_o | output | 4 | Compare-driven output pins |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the steady state of restart-on-compare. Each compare event must land on exactly the right prescale wrap, so only the spacing between consecutive output toggles exposes an off-by-one. The bench therefore sweeps compare values 0 to 3 against prescale values 0 to 2, with channel 0 set to toggle. It times the second and third toggles and compares the gap with (M+1)(P+1). Capture values are checked against a counter that has been stopped at a known count, so the synchroniser latency cannot blur the expected value.

// File: rtl/tmr_pkg.sv
// Shared definitions for the capture/match timer: register word map and
// compare output action codes. Assumes a 4-bit word address.
package tmr_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [3:0] {
        REG_CTRL   = 4'd0,
        REG_PRE    = 4'd1,
        REG_PCNT   = 4'd2,
        REG_TCNT   = 4'd3,
        REG_MCTRL  = 4'd4,
        REG_OCTRL  = 4'd5,
        REG_CCTRL  = 4'd6,
        REG_ISTAT  = 4'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } match_act_e;
endpackage

// File: rtl/tmr_counter.sv
// Prescale counter and timer counter pair. The prescaler wraps when it reaches
// the programmed value and then issues a one-cycle tick to the timer counter.
// Assumes the restart and stop requests are only meaningful in tick cycles.
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         pause,
    input  logic         clr,
    input  logic [W-1:0] prescale,
    input  logic         restart,
    input  logic         hold,
    output logic         tick,
    output logic [W-1:0] pcnt,
    output logic [W-1:0] tcnt
);
    logic live;

    // Counting is allowed only when enabled, not paused and not cleared.
    always_comb begin
        live = run && !pause && !clr;
        tick = live && (pcnt >= prescale);
    end

    // Advance the prescaler and, on each wrap, the timer count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt <= '0;
            tcnt <= '0;
        end else if (live) begin
            if (tick) begin
                pcnt <= '0;
                if (restart)
                    tcnt <= '0;
                else if (!hold)
                    tcnt <= tcnt + 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pcnt == '0);                                   // R2
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !clr) |=> ($stable(pcnt) && $stable(tcnt)));  // R4
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pcnt == '0 && tcnt == '0));                    // R3
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart) |=> tcnt == '0);                      // R7
endmodule

// File: rtl/tmr_match_chan.sv
// One compare channel: flags an event when the timer is about to advance
// while equal to the compare value, and applies the selected pin action.
module tmr_match_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] tcnt,
    input  logic [W-1:0] cmp_val,
    input  logic [1:0]   act,
    output logic         evt,
    output logic         pin
);
    import tmr_pkg::*;

    // A hit counts only in a prescale-wrap cycle.
    always_comb evt = tick && (tcnt == cmp_val);

    // Apply the selected action to the output pin on each hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (evt) begin
            case (match_act_e'(act))
                ACT_LOW:    pin <= 1'b0;
                ACT_HIGH:   pin <= 1'b1;
                ACT_TOGGLE: pin <= ~pin;
                default:    pin <= pin;
            endcase
        end
    end

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && act == 2'b11) |=> pin != $past(pin));           // R6
    AST_NONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'b00) |=> $stable(pin));                       // R6
endmodule

// File: rtl/tmr_capture_chan.sv
// One capture channel: two-flop synchroniser, edge detector with separate
// rising/falling enables, and a capture register that takes the timer count.
// Assumes cap_in is asynchronous to clk.
module tmr_capture_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic         rise_en,
    input  logic         fall_en,
    input  logic [W-1:0] tcnt,
    output logic         evt,
    output logic [W-1:0] cap_val
);
    logic sync1, sync2, prev;

    // Synchronise the pin and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= cap_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Qualify the detected edge with its enable.
    always_comb evt = (rise_en && sync2 && !prev) || (fall_en && !sync2 && prev);

    // Store the timer count on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_val <= '0;
        else if (evt)
            cap_val <= tcnt;
    end

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> cap_val == $past(tcnt));                        // R9
    AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cap_val));                             // R9
endmodule

// File: rtl/capmatch_timer.sv
// Top of the capture/match timer: holds the software registers, combines
// channel events into counter control and interrupt flags, and muxes reads.
// Assumes single-cycle register writes and combinational reads.
module capmatch_timer #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4,
    parameter int NUM_CAP   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pause_i,
    input  logic [NUM_CAP-1:0]        cap_i,
    input  logic                      bus_wr,
    input  logic [tmr_pkg::ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]          bus_wdata,
    output logic [CNT_W-1:0]          bus_rdata,
    output logic [NUM_MATCH-1:0]      match_o,
    output logic                      irq_o
);
    import tmr_pkg::*;

    localparam int NFLAG = NUM_MATCH + NUM_CAP;

    logic                 en_q, clr_q;
    logic [CNT_W-1:0]     pre_q;
    logic [NUM_MATCH-1:0] m_irq_en, m_rst_en, m_stop_en;
    logic [2*NUM_MATCH-1:0] act_q;
    logic [NUM_CAP-1:0]   c_rise_en, c_fall_en, c_irq_en;
    logic [NFLAG-1:0]     istat;
    logic [CNT_W-1:0]     cmp_q [NUM_MATCH];
    logic [CNT_W-1:0]     cap_q [NUM_CAP];

    logic                 tick;
    logic [CNT_W-1:0]     pcnt, tcnt;
    logic [NUM_MATCH-1:0] m_evt;
    logic [NUM_CAP-1:0]   c_evt;
    logic                 any_rst, any_stop;
    logic                 wr_ctrl, wr_istat;

    // Decode the writes that need more than a one-line load.
    always_comb begin
        wr_ctrl  = bus_wr && bus_addr == REG_CTRL;
        wr_istat = bus_wr && bus_addr == REG_ISTAT;
        any_rst  = |(m_evt & m_rst_en);
        any_stop = |(m_evt & m_stop_en);
    end

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(en_q), .pause(pause_i), .clr(clr_q),
        .prescale(pre_q), .restart(any_rst), .hold(any_stop),
        .tick(tick), .pcnt(pcnt), .tcnt(tcnt)
    );

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
        tmr_match_chan #(.W(CNT_W)) u_m (
            .clk(clk), .rst_n(rst_n), .tick(tick), .tcnt(tcnt),
            .cmp_val(cmp_q[i]), .act(act_q[2*i+1:2*i]),
            .evt(m_evt[i]), .pin(match_o[i])
        );
    end

    for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
        tmr_capture_chan #(.W(CNT_W)) u_c (
            .clk(clk), .rst_n(rst_n), .cap_in(cap_i[i]),
            .rise_en(c_rise_en[i]), .fall_en(c_fall_en[i]), .tcnt(tcnt),
            .evt(c_evt[i]), .cap_val(cap_q[i])
        );
    end

    // Control word: software loads it; stop-on-compare then clears the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= bus_wdata[0];
                clr_q <= bus_wdata[1];
            end
            if (any_stop)
                en_q <= 1'b0;
        end
    end

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            m_irq_en  <= '0;
            m_rst_en  <= '0;
            m_stop_en <= '0;
            act_q     <= '0;
            c_rise_en <= '0;
            c_fall_en <= '0;
            c_irq_en  <= '0;
            for (int i = 0; i < NUM_MATCH; i++) cmp_q[i] <= '0;
        end else if (bus_wr) begin
            if (bus_addr == REG_PRE) pre_q <= bus_wdata;
            if (bus_addr == REG_OCTRL) act_q <= bus_wdata[2*NUM_MATCH-1:0];
            if (bus_addr == REG_MCTRL) begin
                for (int i = 0; i < NUM_MATCH; i++) begin
                    m_irq_en[i]  <= bus_wdata[4*i];
                    m_rst_en[i]  <= bus_wdata[4*i+1];
                    m_stop_en[i] <= bus_wdata[4*i+2];
                end
            end
            if (bus_addr == REG_CCTRL) begin
                for (int i = 0; i < NUM_CAP; i++) begin
                    c_rise_en[i] <= bus_wdata[3*i];
                    c_fall_en[i] <= bus_wdata[3*i+1];
                    c_irq_en[i]  <= bus_wdata[3*i+2];
                end
            end
            for (int i = 0; i < NUM_MATCH; i++)
                if (int'(bus_addr) == 8 + i) cmp_q[i] <= bus_wdata;
        end
    end

    // Sticky flags: new events win over a write-one-to-clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            istat <= '0;
        else
            istat <= (istat & ~(wr_istat ? bus_wdata[NFLAG-1:0] : {NFLAG{1'b0}}))
                     | {c_evt, m_evt};
    end

    // Interrupt request from enabled flags.
    always_comb irq_o = |(istat & {c_irq_en, m_irq_en});

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL:  bus_rdata = CNT_W'({clr_q, en_q});
            REG_PRE:   bus_rdata = pre_q;
            REG_PCNT:  bus_rdata = pcnt;
            REG_TCNT:  bus_rdata = tcnt;
            REG_OCTRL: bus_rdata = CNT_W'(act_q);
            REG_ISTAT: bus_rdata = CNT_W'(istat);
            REG_MCTRL:
                for (int i = 0; i < NUM_MATCH; i++) begin
                    bus_rdata[4*i]   = m_irq_en[i];
                    bus_rdata[4*i+1] = m_rst_en[i];
                    bus_rdata[4*i+2] = m_stop_en[i];
                end
            REG_CCTRL:
                for (int i = 0; i < NUM_CAP; i++) begin
                    bus_rdata[3*i]   = c_rise_en[i];
                    bus_rdata[3*i+1] = c_fall_en[i];
                    bus_rdata[3*i+2] = c_irq_en[i];
                end
            default: begin
                for (int i = 0; i < NUM_MATCH; i++)
                    if (int'(bus_addr) == 8 + i) bus_rdata = cmp_q[i];
                for (int i = 0; i < NUM_CAP; i++)
                    if (int'(bus_addr) == 12 + i) bus_rdata = cap_q[i];
            end
        endcase
    end

    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        any_stop |=> !en_q);                                    // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_istat |=> ((istat & $past(istat)) == $past(istat)));  // R10
    AST_EVT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        |m_evt |=> ((istat & NFLAG'($past(m_evt))) == NFLAG'($past(m_evt)))); // R5
endmodule

// File: tb/capmatch_timer_test.sv
module capmatch_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pause_i = 1'b0;
    logic [3:0]  cap_i = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  match_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [3:0] exp_out = '0;
    logic [31:0] exp_cap [4];
    logic [31:0] rv, rv2;

    capmatch_timer uut (
        .clk(clk), .rst_n(rst_n), .pause_i(pause_i), .cap_i(cap_i),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .match_o(match_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    // Clear the counters, then count for k enabled cycles and stop.
    task automatic run(input int k);
        wr(0, 32'd2);
        wr(0, 32'd1);
        repeat (k - 1) @(posedge clk);
        wr(0, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_cap[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(a, rv);
            chk($sformatf("R1 reg %0d", a), rv, 0);
        end
        chk("R1 match_o", 32'(match_o), 0);
        chk("R1 irq_o", 32'(irq_o), 0);

        // R11: read-only words ignore writes
        wr(3, 32'h55); rd(3, rv); chk("R11 tcnt write", rv, 0);
        wr(2, 32'h7);  rd(2, rv); chk("R11 pcnt write", rv, 0);
        wr(13, 32'h9); rd(13, rv); chk("R11 cap write", rv, 0);

        // R2: prescale sweep
        for (int p = 0; p < 4; p++) begin
            wr(1, 32'(p));
            for (int k = 1; k < 10; k++) begin
                run(k);
                rd(3, rv); chk($sformatf("R2 tcnt p=%0d k=%0d", p, k), rv, 32'(k / (p + 1)));
                rd(2, rv); chk($sformatf("R2 pcnt p=%0d k=%0d", p, k), rv, 32'(k % (p + 1)));
            end
        end

        // R3: clear bit holds counters at zero even when enabled
        run(6);
        wr(0, 32'd3);
        repeat (5) @(posedge clk);
        rd(3, rv); chk("R3 tcnt held", rv, 0);
        rd(2, rv); chk("R3 pcnt held", rv, 0);
        wr(0, 32'd0);

        // R4: pause freezes, release resumes
        wr(1, 32'd1);
        wr(0, 32'd2); wr(0, 32'd1);
        repeat (7) @(posedge clk);
        @(negedge clk) pause_i = 1'b1;
        rd(3, rv); rd(2, rv2);
        repeat (10) @(posedge clk);
        begin
            logic [31:0] t2, p2;
            rd(3, t2); rd(2, p2);
            chk("R4 tcnt frozen", t2, rv);
            chk("R4 pcnt frozen", p2, rv2);
        end
        @(negedge clk) pause_i = 1'b0;
        repeat (4) @(posedge clk);
        rd(3, rv2);
        chk("R4 resumes", 32'(rv2 > rv), 1);
        wr(0, 32'd0);
        wr(1, 32'd0);

        // R5 R6 R10: output actions, compare flags, interrupt and clear
        for (int n = 0; n < 4; n++) begin
            wr(8 + n, 32'd3);
            wr(4, 32'd1 << (4 * n));
            for (int s = 0; s < 5; s++) begin
                logic [1:0] a;
                a = (s == 0) ? 2'b10 : (s == 1) ? 2'b00 : (s == 2) ? 2'b01 : 2'b11;
                wr(5, 32'(a) << (2 * n));
                wr(7, 32'hFF);
                run(8);
                case (a)
                    2'b01: exp_out[n] = 1'b0;
                    2'b10: exp_out[n] = 1'b1;
                    2'b11: exp_out[n] = ~exp_out[n];
                    default: ;
                endcase
                chk($sformatf("R6 ch%0d act%0d", n, a), 32'(match_o[n]), 32'(exp_out[n]));
                rd(7, rv);
                chk($sformatf("R5 flag ch%0d", n), 32'(rv[n]), 1);
                chk($sformatf("R10 irq ch%0d", n), 32'(irq_o), 1);
                wr(7, 32'd1 << n);
                rd(7, rv);
                chk($sformatf("R10 w1c ch%0d", n), 32'(rv[n]), 0);
                chk($sformatf("R10 irq low ch%0d", n), 32'(irq_o), 0);
            end
            wr(5, 32'd0);
            wr(8 + n, 32'd0);
        end
        wr(4, 32'd0);

        // R7: restart-on-compare period sweep on channel 0 with toggle
        for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 4; m++) begin
                int t [3];
                int seen;
                logic last;
                wr(0, 32'd2);
                wr(1, 32'(p));
                wr(8, 32'(m));
                wr(4, 32'h2);
                wr(5, 32'h3);
                wr(0, 32'd1);
                seen = 0;
                @(negedge clk); last = match_o[0];
                for (int w = 0; w < 200 && seen < 3; w++) begin
                    @(negedge clk);
                    if (match_o[0] !== last) begin
                        t[seen] = cyc;
                        seen++;
                        last = match_o[0];
                    end
                end
                chk($sformatf("R7 period p=%0d m=%0d", p, m),
                    32'((seen == 3) ? t[2] - t[1] : 0), 32'((m + 1) * (p + 1)));
                wr(0, 32'd0);
                wr(5, 32'd0);
                @(negedge clk); exp_out[0] = match_o[0];
            end
        end
        wr(4, 32'd0);
        wr(1, 32'd0);

        // R8: stop-on-compare on channel 1
        wr(9, 32'd5);
        wr(4, 32'h4 << 4);
        wr(0, 32'd2); wr(0, 32'd1);
        repeat (20) @(posedge clk);
        rd(0, rv); chk("R8 enable cleared", rv, 0);
        rd(3, rv); chk("R8 tcnt held at compare", rv, 5);
        wr(4, 32'd0);
        wr(9, 32'd0);

        // R9 R10: capture edge-enable sweep
        for (int n = 0; n < 4; n++) begin
            for (int c = 0; c < 4; c++) begin
                int v1;
                v1 = 10 + n * 8 + c * 2;
                wr(6, (32'(c) | 32'd4) << (3 * n));
                wr(7, 32'hFF);
                run(v1);
                @(negedge clk) cap_i[n] = 1'b1;
                repeat (4) @(posedge clk);
                if (c[0]) exp_cap[n] = 32'(v1);
                rd(12 + n, rv);
                chk($sformatf("R9 rise ch%0d cfg%0d", n, c), rv, exp_cap[n]);
                run(v1 + 1);
                @(negedge clk) cap_i[n] = 1'b0;
                repeat (4) @(posedge clk);
                if (c[1]) exp_cap[n] = 32'(v1 + 1);
                rd(12 + n, rv);
                chk($sformatf("R9 fall ch%0d cfg%0d", n, c), rv, exp_cap[n]);
                rd(7, rv);
                chk($sformatf("R10 cap flag ch%0d cfg%0d", n, c), 32'(rv[4 + n]), 32'(c != 0));
                chk($sformatf("R10 cap irq ch%0d cfg%0d", n, c), 32'(irq_o), 32'(c != 0));
                wr(7, 32'hF0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule